// File: doc/BRIEF.md
# Little-Endian Address Munging Unit

This block sits between a load/store unit and a 64-bit big-endian data bus. It gives a processor a little-endian mode that can be chosen at run time. It does this by rewriting the three low address bits of each aligned access and never reorders data bytes. An exclusive-OR constant, picked by the operand size, is applied to the byte offset within the doubleword. Accesses flagged as page-table walks always keep the plain big-endian address. Vector operands (128-bit) are handled as doublewords.

The active mode bit can be written directly. A second bit holds the mode to adopt on trap entry, and a trap-entry strobe copies it into the active bit. Each request is registered, and one cycle later the unit returns:
- the adjusted byte address,
- eight byte-lane enables,
- an alignment flag.

A strap input selects a board that reverses all eight bytes of every bus transfer, in both directions.

Top module: `endian_addr_munge`

## Requirements
- R1: After reset the active mode is big-endian (`leMode` = 0), the trap-entry mode bit is 0, `rspValid` is 0, `rspLanes` is 0 and `rspMisalign` is 0.
- R2: A write through `modeWrEn` changes `leMode` at the next clock edge. A request presented in the same cycle as the write is still handled in the old mode, and requests in later cycles use the new mode.
- R3: `trapModeWrEn` loads the trap-entry mode bit. A `trapEnter` pulse copies that bit, as held before the edge, into the active mode. If `trapEnter` and `modeWrEn` occur in the same cycle, the trap copy wins.
- R4: In little-endian mode, an aligned access that is not a table walk has its address bits [2:0] XORed with a constant set by `reqSize`: code 0 (byte) uses 7, code 1 (halfword) uses 6, code 2 (word) uses 4.
- R5: In big-endian mode the returned address equals the request address.
- R6: An access with `reqTableWalk` = 1 returns the unmodified address whatever the mode.
- R7: `reqSize` codes 3 (doubleword), 4 (128-bit vector) and 5 to 7 are all handled as 8-byte operands: the XOR constant is 0 and all eight lanes are enabled.
- R8: An access whose offset is not a multiple of its operand size sets `rspMisalign`, returns the unmodified address and enables no lanes.
- R9: For an aligned access, bit i of `rspLanes` is set exactly for the byte offsets i covered by the operand at the returned address. Lane 0 is the most significant byte of the bus (bits 63:56).
- R10: Each request with `reqValid` = 1 produces `rspValid` = 1 with its results one clock cycle later. Address bits above bit 2 pass through unchanged.
- R11: With `boardSwap` = 1, `wrDataBus` is `wrData` with its eight bytes reversed and `rdData` is `busRdData` reversed. With `boardSwap` = 0 both pass straight through. The path is combinational.
- R12: A doubleword stored in one mode and loaded at the same address in the other mode uses the same bus address and the same bus data, provided `boardSwap` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Write strobe for the active mode bit |
| modeWrVal | input | 1 | Value for the active mode bit (1 = little-endian) |
| trapModeWrEn | input | 1 | Write strobe for the trap-entry mode bit |
| trapModeWrVal | input | 1 | Value for the trap-entry mode bit |
| trapEnter | input | 1 | Trap-entry strobe; copies the trap-entry bit into the active mode |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Effective byte address |
| reqSize | input | 3 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword, 4 vector |
| reqTableWalk | input | 1 | Access belongs to a page-table walk |
| boardSwap | input | 1 | Strap: board reverses bus bytes |
| wrData | input | 64 | Store data from the load/store unit |
| busRdData | input | 64 | Load data from the bus |
| rspValid | output | 1 | Result valid |
| rspAddr | output | ADDR_W | Adjusted byte address |
| rspLanes | output | 8 | Byte-lane enables, bit 0 = most significant lane |
| rspMisalign | output | 1 | Access not naturally aligned |
| leMode | output | 1 | Current active mode (1 = little-endian) |
| wrDataBus | output | 64 | Store data driven onto the bus |
| rdData | output | 64 | Load data returned to the load/store unit |

## Verification
The assertions assume the inputs are at known levels from reset onward. They also assume `reqValid` is low while reset is held, so that the first response after reset relates to a real request. The bench drives every input on the falling clock edge and holds `reqValid` low during reset. It then sweeps all size codes, all eight offsets, both modes and both table-walk settings. Mode changes are made only through the two write strobes and the trap strobe, so the mode the checker sees always follows those strobes.

// File: rtl/endian_munge_pkg.sv
package endian_munge_pkg;

  // Strobes handed from control to datapath for one request.
  typedef struct packed {
    logic fire;      // request accepted this cycle
    logic munge;     // apply the size-dependent XOR to the offset
    logic misalign;  // offset not a multiple of the operand size
  } mungeStrobe_t;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_VEC   = 3'd4
  } opSize_e;

endpackage

// File: rtl/endian_munge_ctrl.sv
module endian_munge_ctrl
  import endian_munge_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  localparam int OFF_W = $clog2(BUS_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic             modeWrVal,
  input  logic             trapModeWrEn,
  input  logic             trapModeWrVal,
  input  logic             trapEnter,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  input  logic             reqTableWalk,
  output mungeStrobe_t     strb,
  output logic [OFF_W-1:0] lowMask,
  output logic             leMode
);

  logic activeLe;
  logic trapLe;

  // Mode state: trap entry takes priority over a direct write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeLe <= 1'b0;
      trapLe   <= 1'b0;
    end else begin
      if (trapModeWrEn) trapLe <= trapModeWrVal;
      if (trapEnter)     activeLe <= trapLe;
      else if (modeWrEn) activeLe <= modeWrVal;
    end
  end

  // Operand size mask; codes at or beyond the bus width saturate to a full doubleword.
  always_comb begin
    if (reqSize >= 3'(OFF_W)) lowMask = '1;
    else                      lowMask = OFF_W'((1 << reqSize) - 1);
  end

  logic misalignNow;
  assign misalignNow = reqValid && (|(reqOffset & lowMask));

  always_comb begin
    strb.fire     = reqValid;
    strb.misalign = misalignNow;
    strb.munge    = reqValid && activeLe && !reqTableWalk && !misalignNow;
  end

  assign leMode = activeLe;

endmodule

// File: rtl/endian_munge_dp.sv
module endian_munge_dp
  import endian_munge_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  localparam int OFF_W  = $clog2(BUS_BYTES),
  localparam int DATA_W = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mungeStrobe_t         strb,
  input  logic [OFF_W-1:0]     lowMask,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 boardSwap,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    busRdData,
  output logic                 rspValid,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [BUS_BYTES-1:0] rspLanes,
  output logic                 rspMisalign,
  output logic [DATA_W-1:0]    wrDataBus,
  output logic [DATA_W-1:0]    rdData
);

  logic [OFF_W-1:0]     xorConst;
  logic [OFF_W-1:0]     mungedOff;
  logic [BUS_BYTES-1:0] laneHit;

  assign xorConst  = lowMask ^ {OFF_W{1'b1}};
  assign mungedOff = strb.munge ? (reqAddr[OFF_W-1:0] ^ xorConst) : reqAddr[OFF_W-1:0];

  // A lane is enabled when it falls in the same size-aligned group as the offset.
  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(g);
    assign laneHit[g] = strb.fire && !strb.misalign &&
                        ((LANE & ~lowMask) == (mungedOff & ~lowMask));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspAddr     <= '0;
      rspLanes    <= '0;
      rspMisalign <= 1'b0;
    end else begin
      rspValid    <= strb.fire;
      rspAddr     <= {reqAddr[ADDR_W-1:OFF_W], mungedOff};
      rspLanes    <= laneHit;
      rspMisalign <= strb.misalign;
    end
  end

  // Board byte reversal, both directions.
  logic [DATA_W-1:0] wrRev;
  logic [DATA_W-1:0] rdRev;
  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_swap
    assign wrRev[8*b +: 8] = wrData[8*(BUS_BYTES-1-b) +: 8];
    assign rdRev[8*b +: 8] = busRdData[8*(BUS_BYTES-1-b) +: 8];
  end

  assign wrDataBus = boardSwap ? wrRev : wrData;
  assign rdData    = boardSwap ? rdRev : busRdData;

endmodule

// File: rtl/endian_addr_munge.sv
module endian_addr_munge
  import endian_munge_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  localparam int OFF_W  = $clog2(BUS_BYTES),
  localparam int DATA_W = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeWrEn,
  input  logic                 modeWrVal,
  input  logic                 trapModeWrEn,
  input  logic                 trapModeWrVal,
  input  logic                 trapEnter,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [2:0]           reqSize,
  input  logic                 reqTableWalk,
  input  logic                 boardSwap,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    busRdData,
  output logic                 rspValid,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [BUS_BYTES-1:0] rspLanes,
  output logic                 rspMisalign,
  output logic                 leMode,
  output logic [DATA_W-1:0]    wrDataBus,
  output logic [DATA_W-1:0]    rdData
);

  mungeStrobe_t     strb;
  logic [OFF_W-1:0] lowMask;

  endian_munge_ctrl #(.BUS_BYTES(BUS_BYTES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeWrEn     (modeWrEn),
    .modeWrVal    (modeWrVal),
    .trapModeWrEn (trapModeWrEn),
    .trapModeWrVal(trapModeWrVal),
    .trapEnter    (trapEnter),
    .reqValid     (reqValid),
    .reqOffset    (reqAddr[OFF_W-1:0]),
    .reqSize      (reqSize),
    .reqTableWalk (reqTableWalk),
    .strb         (strb),
    .lowMask      (lowMask),
    .leMode       (leMode)
  );

  endian_munge_dp #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lowMask    (lowMask),
    .reqAddr    (reqAddr),
    .boardSwap  (boardSwap),
    .wrData     (wrData),
    .busRdData  (busRdData),
    .rspValid   (rspValid),
    .rspAddr    (rspAddr),
    .rspLanes   (rspLanes),
    .rspMisalign(rspMisalign),
    .wrDataBus  (wrDataBus),
    .rdData     (rdData)
  );

endmodule

// File: rtl/endian_addr_munge_chk.sv
module endian_addr_munge_chk #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 modeWrEn,
  input logic                 trapEnter,
  input logic                 reqValid,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic [2:0]           reqSize,
  input logic                 reqTableWalk,
  input logic                 rspValid,
  input logic [ADDR_W-1:0]    rspAddr,
  input logic [BUS_BYTES-1:0] rspLanes,
  input logic                 rspMisalign,
  input logic                 leMode
);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWrEn && !trapEnter) |=> $stable(leMode));

  p_be_passthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !leMode) |=> (rspAddr == $past(reqAddr)));

  p_tablewalk_be_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTableWalk) |=> (rspAddr == $past(reqAddr)));

  p_dword_flat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize >= 3'd3 && reqAddr[2:0] == 3'd0) |=>
      (rspAddr == $past(reqAddr) && rspLanes == '1));

  p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspMisalign |-> (rspLanes == '0));

  p_lane_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspMisalign) |->
      ($countones(rspLanes) == 1 || $countones(rspLanes) == 2 ||
       $countones(rspLanes) == 4 || $countones(rspLanes) == 8));

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspAddr[ADDR_W-1:3] == $past(reqAddr[ADDR_W-1:3])));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspLanes == '0));

endmodule

bind endian_addr_munge endian_addr_munge_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .modeWrEn    (modeWrEn),
  .trapEnter   (trapEnter),
  .reqValid    (reqValid),
  .reqAddr     (reqAddr),
  .reqSize     (reqSize),
  .reqTableWalk(reqTableWalk),
  .rspValid    (rspValid),
  .rspAddr     (rspAddr),
  .rspLanes    (rspLanes),
  .rspMisalign (rspMisalign),
  .leMode      (leMode)
);

// File: tb/endian_addr_munge_tb.sv
module endian_addr_munge_tb;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN, modeWrEn, modeWrVal, trapModeWrEn, trapModeWrVal, trapEnter;
  logic        reqValid, reqTableWalk, boardSwap;
  logic [31:0] reqAddr;
  logic [2:0]  reqSize;
  logic [63:0] wrData, busRdData, wrDataBus, rdData;
  logic        rspValid, rspMisalign, leMode;
  logic [31:0] rspAddr;
  logic [7:0]  rspLanes;

  endian_addr_munge #(.ADDR_W(ADDR_W), .BUS_BYTES(8)) u_dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrVal(modeWrVal),
    .trapModeWrEn(trapModeWrEn), .trapModeWrVal(trapModeWrVal), .trapEnter(trapEnter),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize), .reqTableWalk(reqTableWalk),
    .boardSwap(boardSwap), .wrData(wrData), .busRdData(busRdData),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspLanes(rspLanes), .rspMisalign(rspMisalign),
    .leMode(leMode), .wrDataBus(wrDataBus), .rdData(rdData)
  );

  int nChk = 0;
  int nBad = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rev8(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    return r;
  endfunction

  // Issue one request and check the response one cycle later.
  task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic tw, input logic le);
    int n, off, eOff;
    logic mis;
    logic [7:0] eLanes;
    string tag;
    n   = (sz >= 3) ? 8 : (1 << sz);
    off = int'(a[2:0]);
    mis = (off % n) != 0;
    eOff = (!mis && le && !tw) ? (off ^ (7 ^ (n - 1))) : off;
    eLanes = '0;
    for (int i = 0; i < 8; i++) if (!mis && i >= eOff && i < eOff + n) eLanes[i] = 1'b1;
    if (mis)           tag = "R8";
    else if (tw)       tag = "R6";
    else if (sz >= 3)  tag = "R7";
    else if (le)       tag = "R4";
    else               tag = "R5";
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqTableWalk = tw;
    @(negedge clk);
    reqValid = 1'b0; reqTableWalk = 1'b0;
    chk("R10", "rspValid", 64'(rspValid), 64'd1);
    chk(tag, "rspAddr", 64'(rspAddr), 64'({a[31:3], 3'(eOff)}));
    chk("R9", "rspLanes", 64'(rspLanes), 64'(eLanes));
    chk("R8", "rspMisalign", 64'(rspMisalign), 64'(mis));
  endtask

  task automatic setMode(input logic v);
    @(negedge clk); modeWrEn = 1'b1; modeWrVal = v;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeWrEn = 0; modeWrVal = 0; trapModeWrEn = 0; trapModeWrVal = 0;
    trapEnter = 0; reqValid = 0; reqAddr = '0; reqSize = '0; reqTableWalk = 0;
    boardSwap = 0; wrData = '0; busRdData = '0;
    repeat (3) @(negedge clk);
    chk("R1", "leMode", 64'(leMode), 64'd0);
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "rspLanes", 64'(rspLanes), 64'd0);
    chk("R1", "rspMisalign", 64'(rspMisalign), 64'd0);
    rstN = 1'b1;
    // Default big-endian: byte at offset 0 not munged (R1).
    access(32'h1000_0000, 3'd0, 1'b0, 1'b0);

    // Sweep: mode x table walk x size code x offset.
    for (int le = 0; le < 2; le++) begin
      setMode(le[0]);
      chk("R2", "leMode after write", 64'(leMode), 64'(le));
      for (int tw = 0; tw < 2; tw++)
        for (int sz = 0; sz < 8; sz++)
          for (int off = 0; off < 8; off++)
            access(32'hA5F0_0000 + 32'((sz * 8 + tw * 64 + off * 131) << 3) + 32'(off),
                   3'(sz), tw[0], le[0]);
    end

    // R2: write in the same cycle as a request does not affect it.
    setMode(1'b0);
    @(negedge clk);
    modeWrEn = 1'b1; modeWrVal = 1'b1;
    reqValid = 1'b1; reqAddr = 32'h0000_2000; reqSize = 3'd0;
    @(negedge clk);
    modeWrEn = 1'b0; reqValid = 1'b0;
    chk("R2", "same-cycle request addr", 64'(rspAddr), 64'h2000);
    access(32'h0000_2000, 3'd0, 1'b0, 1'b1);

    // R3: trap entry copies the trap-entry bit and beats a direct write.
    @(negedge clk); trapModeWrEn = 1'b1; trapModeWrVal = 1'b0;
    @(negedge clk); trapModeWrEn = 1'b0;
    setMode(1'b1);
    @(negedge clk); trapEnter = 1'b1; modeWrEn = 1'b1; modeWrVal = 1'b1;
    @(negedge clk); trapEnter = 1'b0; modeWrEn = 1'b0;
    chk("R3", "leMode after trap (bit 0)", 64'(leMode), 64'd0);
    @(negedge clk); trapModeWrEn = 1'b1; trapModeWrVal = 1'b1;
    @(negedge clk); trapModeWrEn = 1'b0;
    chk("R3", "leMode unchanged by trap bit write", 64'(leMode), 64'd0);
    @(negedge clk); trapEnter = 1'b1;
    @(negedge clk); trapEnter = 1'b0;
    chk("R3", "leMode after trap (bit 1)", 64'(leMode), 64'd1);
    access(32'h0000_3001, 3'd0, 1'b0, 1'b1);

    // R11: board swap in both directions.
    wrData = 64'h0102_0304_0506_0708; busRdData = 64'h1122_3344_5566_7788;
    boardSwap = 1'b0; #1;
    chk("R11", "wr passthrough", wrDataBus, wrData);
    chk("R11", "rd passthrough", rdData, busRdData);
    boardSwap = 1'b1; #1;
    chk("R11", "wr swapped", wrDataBus, 64'h0807_0605_0403_0201);
    chk("R11", "rd swapped", rdData, 64'h8877_6655_4433_2211);

    // R12: doubleword store in one mode, load in the other.
    begin
      logic [31:0] stAddr;
      logic [63:0] stBus;
      setMode(1'b0);
      access(32'h0000_4008, 3'd3, 1'b0, 1'b0);
      stAddr = rspAddr;
      wrData = 64'hDEAD_BEEF_0BAD_F00D; #1;
      stBus = wrDataBus;
      setMode(1'b1);
      access(32'h0000_4008, 3'd3, 1'b0, 1'b1);
      chk("R12", "dword addr across modes", 64'(rspAddr), 64'(stAddr));
      busRdData = stBus; #1;
      chk("R12", "dword data round trip", rdData, 64'hDEAD_BEEF_0BAD_F00D);
      chk("R12", "bus image", stBus, rev8(64'hDEAD_BEEF_0BAD_F00D));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule